// File: doc/BRIEF.md
# Immediate Extension and Target Unit

This unit sits in the decode stage of a 32-bit load/store core. It receives one instruction word and the address of that instruction. From these it derives the operand that the ALU takes in place of a second register, the destination of a conditional branch, and the destination of an absolute jump. It also splits out the opcode, the register specifiers, the shift amount and the function code, and it classifies the word as register, immediate or jump format. Logic further down the pipe then sees only full-width operands.

The widening rule depends on the opcode. Arithmetic immediates, memory offsets and branch displacements copy bit 15 into every higher bit. The three bitwise-logic immediates fill the upper half with zeros. The load-upper opcode moves the field into the upper half and clears the lower half. The register and jump formats carry no immediate operand, so their operand is zero. A branch displacement counts words: it is shifted left by two and added to the address of the following instruction. A jump keeps the top four bits of that following address and replaces the rest with its 26-bit index shifted left by two.

The parameter `REG_OUT` selects the output stage. With `REG_OUT = 0` the results follow the inputs combinationally. With `REG_OUT = 1` a register captures them on each cycle that carries a valid input.

Top module: `ixt_decode_unit`

## Requirements
- R1: `out_fmt` encodes the format class as 0 for register format, 1 for immediate format and 2 for jump format. Opcode 0 is register format. Opcodes 2 and 3 are jump format. Every other opcode is immediate format.
- R2: The split fields are taken from fixed bit positions of the instruction word: opcode bits 31..26, rs bits 25..21, rt bits 20..16, rd bits 15..11, shamt bits 10..6 and funct bits 5..0.
- R3: For every immediate-format opcode other than 12, 13, 14 and 15, `out_imm` is bits 15..0 with bit 15 copied into bits 31..16. The result therefore lies between 0xFFFF8000 and 0x00007FFF.
- R4: For opcodes 12, 13 and 14, `out_imm` is bits 15..0 with bits 31..16 cleared. The result therefore lies between 0x00000000 and 0x0000FFFF.
- R5: For opcode 15, `out_imm` holds bits 15..0 of the instruction in bits 31..16, and its bits 15..0 are zero.
- R6: For register-format and jump-format words, `out_imm` is zero.
- R7: `out_br_target` equals the instruction address plus 4 plus the sign-extended bits 15..0 shifted left by two, taken modulo 2^32. It is produced for every word.
- R8: `out_j_target` is bits 31..28 of (instruction address + 4), then instruction bits 25..0, then two zero bits. It is produced for every word.
- R9: With `REG_OUT = 0`, every output follows the inputs in the same cycle, and `out_valid` equals `in_valid`.
- R10: With `REG_OUT = 1`, the results for a word accepted with `in_valid` high at a rising edge appear after that edge. `out_valid` is high for exactly the one following cycle for each accepted word.
- R11: With `REG_OUT = 1`, a cycle with `in_valid` low leaves every data output unchanged, whatever the instruction and address inputs carry.
- R12: With `REG_OUT = 1`, while `rst_n` is low, `out_valid` is 0 and every data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and address are valid this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | ADDR_W | Address of the instruction |
| out_valid | output | 1 | Results are valid |
| out_fmt | output | 2 | Format class: 0 register, 1 immediate, 2 jump |
| out_opcode | output | 6 | Opcode field |
| out_rs | output | 5 | First source register specifier |
| out_rt | output | 5 | Second source or target register specifier |
| out_rd | output | 5 | Destination register specifier |
| out_shamt | output | 5 | Shift amount field |
| out_funct | output | 6 | Function code field |
| out_imm | output | DATA_W | Widened immediate operand |
| out_br_target | output | ADDR_W | Conditional branch destination |
| out_j_target | output | ADDR_W | Absolute jump destination |

## Verification
The clocked properties assume that `in_valid` is low throughout reset. They also assume that the instruction and address inputs are settled before each rising edge, because the widening and class checks sample the combinational path at that edge. The stimulus changes inputs only on falling edges and holds `in_valid` low until reset is released. It then presents every one of the 64 opcodes with boundary immediates (0x0000, 0x7FFF, 0x8000 and 0xFFFF) and with addresses chosen so that the next-instruction address wraps past 2^32 and crosses a 256 MiB region boundary. After each accepted word the stimulus drops `in_valid` and scrambles the inputs, so the hold behaviour is exercised at the ports.

// File: rtl/ixt_pkg.sv
package ixt_pkg;

   localparam int OPC_W   = 6;
   localparam int REG_W   = 5;
   localparam int FUNCT_W = 6;
   localparam int IMM_W   = 16;
   localparam int IDX_W   = 26;

   localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
   localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JLINK = 6'd3;
   localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
   localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
   localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
   localparam logic [OPC_W-1:0] OPC_LUPP  = 6'd15;

   typedef enum logic [1:0] {
      FMT_R = 2'd0,
      FMT_I = 2'd1,
      FMT_J = 2'd2
   } fmt_e;

   typedef enum logic [1:0] {
      EXT_SIGN  = 2'd0,
      EXT_ZERO  = 2'd1,
      EXT_UPPER = 2'd2,
      EXT_NONE  = 2'd3
   } ext_e;

   typedef struct packed {
      fmt_e                fmt;
      logic [OPC_W-1:0]    opcode;
      logic [REG_W-1:0]    rs;
      logic [REG_W-1:0]    rt;
      logic [REG_W-1:0]    rd;
      logic [REG_W-1:0]    shamt;
      logic [FUNCT_W-1:0]  funct;
   } fields_t;

endpackage

// File: rtl/ixt_field_split.sv
module ixt_field_split
   import ixt_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr,
   output fields_t            fields,
   output ext_e               ext_mode
);

   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_W;
   localparam int RT_LSB  = RS_LSB - REG_W;
   localparam int RD_LSB  = RT_LSB - REG_W;
   localparam int SH_LSB  = RD_LSB - REG_W;

   initial begin
      assert (INSTR_W == 32)
         else $error("ixt_field_split: INSTR_W must be 32");
   end

   logic [OPC_W-1:0] opc;

   assign opc = instr[INSTR_W-1:OPC_LSB];

   always_comb begin
      fields.opcode = opc;
      fields.rs     = instr[RS_LSB +: REG_W];
      fields.rt     = instr[RT_LSB +: REG_W];
      fields.rd     = instr[RD_LSB +: REG_W];
      fields.shamt  = instr[SH_LSB +: REG_W];
      fields.funct  = instr[FUNCT_W-1:0];
   end

   // The opcode picks both the class and the widening rule.
   always_comb begin
      unique case (opc)
         OPC_REG: begin
            fields.fmt = FMT_R;
            ext_mode   = EXT_NONE;
         end
         OPC_JMP, OPC_JLINK: begin
            fields.fmt = FMT_J;
            ext_mode   = EXT_NONE;
         end
         OPC_ANDI, OPC_ORI, OPC_XORI: begin
            fields.fmt = FMT_I;
            ext_mode   = EXT_ZERO;
         end
         OPC_LUPP: begin
            fields.fmt = FMT_I;
            ext_mode   = EXT_UPPER;
         end
         default: begin
            fields.fmt = FMT_I;
            ext_mode   = EXT_SIGN;
         end
      endcase
   end

endmodule

// File: rtl/ixt_imm_extend.sv
module ixt_imm_extend
   import ixt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [IMM_W-1:0]  imm_raw,
   input  ext_e              mode,
   output logic [DATA_W-1:0] imm_wide
);

   localparam int FILL_W  = DATA_W - IMM_W;
   localparam int UPPER_W = 2 * IMM_W;

   initial begin
      assert (DATA_W >= UPPER_W)
         else $error("ixt_imm_extend: DATA_W must be at least 32");
   end

   logic [DATA_W-1:0] sign_v;
   logic [DATA_W-1:0] zero_v;
   logic [DATA_W-1:0] upper_v;

   assign sign_v = {{FILL_W{imm_raw[IMM_W-1]}}, imm_raw};
   assign zero_v = {{FILL_W{1'b0}}, imm_raw};

   // Load-upper result: exact at 32 bits, sign-widened on wider datapaths.
   generate
      if (DATA_W == UPPER_W) begin : g_upper_exact
         assign upper_v = {imm_raw, {IMM_W{1'b0}}};
      end else begin : g_upper_widen
         assign upper_v = {{(DATA_W-UPPER_W){imm_raw[IMM_W-1]}},
                           imm_raw, {IMM_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      unique case (mode)
         EXT_SIGN:  imm_wide = sign_v;
         EXT_ZERO:  imm_wide = zero_v;
         EXT_UPPER: imm_wide = upper_v;
         default:   imm_wide = '0;
      endcase
   end

endmodule

// File: rtl/ixt_target_gen.sv
module ixt_target_gen
   import ixt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IMM_W-1:0]  br_off,
   input  logic [IDX_W-1:0]  j_index,
   output logic [ADDR_W-1:0] br_target,
   output logic [ADDR_W-1:0] j_target
);

   localparam int SHIFT   = 2;
   localparam int REGION  = IDX_W + SHIFT;
   localparam int OFF_PAD = ADDR_W - IMM_W - SHIFT;

   initial begin
      assert (ADDR_W >= REGION + 2)
         else $error("ixt_target_gen: ADDR_W must be at least 30");
   end

   logic [ADDR_W-1:0] pc_next;
   logic [ADDR_W-1:0] off_scaled;

   assign pc_next    = pc + ADDR_W'(4);
   assign off_scaled = {{OFF_PAD{br_off[IMM_W-1]}}, br_off, {SHIFT{1'b0}}};
   assign br_target  = pc_next + off_scaled;
   assign j_target   = {pc_next[ADDR_W-1:REGION], j_index, {SHIFT{1'b0}}};

endmodule

// File: rtl/ixt_decode_unit.sv
module ixt_decode_unit
   import ixt_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] in_instr,
   input  logic [ADDR_W-1:0]  in_pc,
   output logic               out_valid,
   output logic [1:0]         out_fmt,
   output logic [OPC_W-1:0]   out_opcode,
   output logic [REG_W-1:0]   out_rs,
   output logic [REG_W-1:0]   out_rt,
   output logic [REG_W-1:0]   out_rd,
   output logic [REG_W-1:0]   out_shamt,
   output logic [FUNCT_W-1:0] out_funct,
   output logic [DATA_W-1:0]  out_imm,
   output logic [ADDR_W-1:0]  out_br_target,
   output logic [ADDR_W-1:0]  out_j_target
);

   initial begin
      assert (INSTR_W == 32)
         else $error("ixt_decode_unit: INSTR_W must be 32");
   end

   fields_t           fld_c;
   ext_e              ext_c;
   logic [DATA_W-1:0] imm_c;
   logic [ADDR_W-1:0] br_c;
   logic [ADDR_W-1:0] j_c;

   ixt_field_split #(.INSTR_W(INSTR_W)) u_split (
      .instr    (in_instr),
      .fields   (fld_c),
      .ext_mode (ext_c)
   );

   ixt_imm_extend #(.DATA_W(DATA_W)) u_ext (
      .imm_raw  (in_instr[IMM_W-1:0]),
      .mode     (ext_c),
      .imm_wide (imm_c)
   );

   ixt_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
      .pc        (in_pc),
      .br_off    (in_instr[IMM_W-1:0]),
      .j_index   (in_instr[IDX_W-1:0]),
      .br_target (br_c),
      .j_target  (j_c)
   );

   // Widening and class checks on the combinational path.
   p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_c == EXT_SIGN) |-> (imm_c[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){imm_c[IMM_W-1]}}));
   p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_c == EXT_ZERO) |-> (imm_c[DATA_W-1:IMM_W] == '0));
   p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_c == EXT_UPPER) |-> ((imm_c[IMM_W-1:0] == '0) &&
                                (imm_c[2*IMM_W-1:IMM_W] == in_instr[IMM_W-1:0])));
   p_jump_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_instr[INSTR_W-1:INSTR_W-OPC_W+1] == 5'b00001) |-> (fld_c.fmt == FMT_J));
   p_no_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_c.fmt != FMT_I) |-> (imm_c == '0));

   generate
      if (REG_OUT) begin : g_reg
         logic               vld_q;
         fields_t            fld_q;
         logic [DATA_W-1:0]  imm_q;
         logic [ADDR_W-1:0]  br_q;
         logic [ADDR_W-1:0]  j_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               fld_q <= '0;
               imm_q <= '0;
               br_q  <= '0;
               j_q   <= '0;
            end else begin
               vld_q <= in_valid;
               if (in_valid) begin
                  fld_q <= fld_c;
                  imm_q <= imm_c;
                  br_q  <= br_c;
                  j_q   <= j_c;
               end
            end
         end

         assign out_valid     = vld_q;
         assign out_fmt       = fld_q.fmt;
         assign out_opcode    = fld_q.opcode;
         assign out_rs        = fld_q.rs;
         assign out_rt        = fld_q.rt;
         assign out_rd        = fld_q.rd;
         assign out_shamt     = fld_q.shamt;
         assign out_funct     = fld_q.funct;
         assign out_imm       = imm_q;
         assign out_br_target = br_q;
         assign out_j_target  = j_q;

         p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_imm) && $stable(out_br_target) &&
                           $stable(out_j_target) && $stable(out_opcode)));
      end else begin : g_comb
         assign out_valid     = in_valid;
         assign out_fmt       = fld_c.fmt;
         assign out_opcode    = fld_c.opcode;
         assign out_rs        = fld_c.rs;
         assign out_rt        = fld_c.rt;
         assign out_rd        = fld_c.rd;
         assign out_shamt     = fld_c.shamt;
         assign out_funct     = fld_c.funct;
         assign out_imm       = imm_c;
         assign out_br_target = br_c;
         assign out_j_target  = j_c;

         p_branch_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_br_target[1:0] == in_pc[1:0]);
      end
   endgenerate

endmodule

// File: tb/test_ixt_decode_unit.sv
`timescale 1ns/1ps
module test_ixt_decode_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic [31:0] in_pc = '0;

   logic        rv, cv;
   logic [1:0]  rfmt, cfmt;
   logic [5:0]  ropc, copc, rfn, cfn;
   logic [4:0]  rrs, crs, rrt, crt, rrd, crd, rsh, csh;
   logic [31:0] rimm, cimm, rbr, cbr, rj, cj;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ixt_decode_unit #(.REG_OUT(1'b1)) i_ixt_decode_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr), .in_pc(in_pc),
      .out_valid(rv), .out_fmt(rfmt), .out_opcode(ropc), .out_rs(rrs), .out_rt(rrt),
      .out_rd(rrd), .out_shamt(rsh), .out_funct(rfn), .out_imm(rimm),
      .out_br_target(rbr), .out_j_target(rj)
   );

   ixt_decode_unit #(.REG_OUT(1'b0)) i_ixt_decode_unit_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr), .in_pc(in_pc),
      .out_valid(cv), .out_fmt(cfmt), .out_opcode(copc), .out_rs(crs), .out_rt(crt),
      .out_rd(crd), .out_shamt(csh), .out_funct(cfn), .out_imm(cimm),
      .out_br_target(cbr), .out_j_target(cj)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_fmt(input logic [5:0] opc);
      if (opc == 6'd0) return 2'd0;
      if (opc == 6'd2 || opc == 6'd3) return 2'd2;
      return 2'd1;
   endfunction

   function automatic logic [31:0] exp_imm(input logic [5:0] opc, input logic [15:0] v);
      if (opc == 6'd0 || opc == 6'd2 || opc == 6'd3) return 32'h0;
      if (opc >= 6'd12 && opc <= 6'd14) return 32'(v);
      if (opc == 6'd15) return 32'(v) * 32'h10000;
      return 32'(signed'(v));
   endfunction

   function automatic logic [31:0] exp_br(input logic [31:0] pc, input logic [15:0] v);
      return pc + 32'd4 + (32'(signed'(v)) * 32'd4);
   endfunction

   function automatic logic [31:0] exp_j(input logic [31:0] pc, input logic [25:0] idx);
      logic [31:0] n;
      n = pc + 32'd4;
      return (n & 32'hF000_0000) | (32'(idx) * 32'd4);
   endfunction

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] imms [8];
      logic [31:0] pcs  [6];
      logic [31:0] seed;
      logic [31:0] e_imm, e_br, e_j;
      imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'h1234, 16'hABCD};
      pcs  = '{32'h0000_0000, 32'h0040_1000, 32'hFFFF_FFFC, 32'h0FFF_FFFC,
               32'h8000_0010, 32'h7FFF_FFF8};
      seed = 32'h1357_9BDF;

      repeat (3) @(posedge clk);
      #1;
      chk("R12 reset valid", 32'(rv), 32'h0);
      chk("R12 reset imm", rimm, 32'h0);
      chk("R12 reset branch", rbr, 32'h0);
      chk("R12 reset jump", rj, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int op = 0; op < 64; op++) begin
         for (int k = 0; k < 8; k++) begin
            logic [31:0] w, pc;
            seed = seed * 32'd1664525 + 32'd1013904223;
            w  = {6'(op), seed[25:16], imms[k]};
            pc = pcs[(op + k) % 6];
            e_imm = exp_imm(6'(op), imms[k]);
            e_br  = exp_br(pc, imms[k]);
            e_j   = exp_j(pc, w[25:0]);

            @(negedge clk);
            in_valid = 1'b1;
            in_instr = w;
            in_pc    = pc;
            #1;
            chk("R9 comb valid", 32'(cv), 32'h1);
            chk("R9 comb imm same cycle", cimm, e_imm);
            @(posedge clk);
            #1;
            // comb instance
            chk("R1 format comb", 32'(cfmt), 32'(exp_fmt(6'(op))));
            chk("R2 fields comb", {copc, crs, crt, crd, csh, cfn}, w);
            if (op == 0 || op == 2 || op == 3)      chk("R6 no operand", cimm, e_imm);
            else if (op >= 12 && op <= 14)          chk("R4 zero extend", cimm, e_imm);
            else if (op == 15)                      chk("R5 upper", cimm, e_imm);
            else                                    chk("R3 sign extend", cimm, e_imm);
            chk("R7 branch comb", cbr, e_br);
            chk("R8 jump comb", cj, e_j);
            // registered instance
            chk("R10 reg valid", 32'(rv), 32'h1);
            chk("R10 reg fields", {ropc, rrs, rrt, rrd, rsh, rfn}, w);
            chk("R10 reg format", 32'(rfmt), 32'(exp_fmt(6'(op))));
            chk("R10 reg imm", rimm, e_imm);
            chk("R10 reg branch", rbr, e_br);
            chk("R10 reg jump", rj, e_j);

            @(negedge clk);
            in_valid = 1'b0;
            in_instr = ~w ^ seed;
            in_pc    = pc ^ 32'h5A5A_5A50;
            @(posedge clk);
            #1;
            chk("R10 valid one cycle", 32'(rv), 32'h0);
            chk("R9 comb valid low", 32'(cv), 32'h0);
            chk("R11 hold imm", rimm, e_imm);
            chk("R11 hold branch", rbr, e_br);
            chk("R11 hold jump", rj, e_j);
            chk("R11 hold fields", {ropc, rrs, rrt, rrd, rsh, rfn}, w);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule